// File: doc/BRIEF.md
# AES-128 Inverse Cipher Round Pipeline

This block turns 128-bit ciphertext blocks back into plaintext under AES-128. It is built as a chain of ten registered inverse rounds. One new block may enter on every clock. The caller supplies the whole expanded key schedule as one flat bus, and that bus must stay steady while blocks are in flight. Before the first round, the incoming block is XORed with the last key of the schedule.

Each round stage works in a fixed order. It undoes the row rotation by rotating row r right by r bytes. It then substitutes every byte through the inverse S-box and XORs in the round key for its position. Last, it applies the inverse column mix, built from GF(2^8) products with the constants 0e, 0b, 0d and 09. The tenth stage skips the column mix. A stage loads a new state only when the stage before it signals done, and its own done pulse enables the next stage.

Top module: `aes_inv_pipe`

## Requirements
- R1: After reset, `out_valid` is 0 and `plain_o` is all zeros. Both stay that way until a block is presented.
- R2: Byte n of a block (n = 0..15) sits at bits [127-8n:120-8n]. It is the byte in row n mod 4 and column n div 4. With the schedule expanded from key 000102030405060708090a0b0c0d0e0f, ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a yields plaintext 00112233445566778899aabbccddeeff.
- R3: Round key k occupies bits [128k+127:128k] of `rkeys_i`. Key 0 is the cipher key and key 10 is the last expanded key. The input is XORed with key 10 first, and stage r uses key 10-r. Any key and plaintext encrypted by the standard cipher therefore decrypt back to the plaintext.
- R4: A block sampled with `in_valid` high at a rising edge appears on `plain_o`, with `out_valid` high, right after the tenth rising edge counted from that edge. Before then `out_valid` stays low.
- R5: Blocks presented on consecutive cycles leave on consecutive cycles, in the order they entered, each decrypted correctly.
- R6: When no block arrives, `out_valid` drops after the last block has left, and `plain_o` keeps the last plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Ciphertext on `cipher_i` is taken this cycle |
| cipher_i | input | 128 | Ciphertext block |
| rkeys_i | input | 1408 | Expanded schedule, key k at bits [128k+127:128k] |
| out_valid | output | 1 | `plain_o` holds a newly finished block |
| plain_o | output | 128 | Plaintext block |

## Verification
The bench goes after these corner cases, each noted with how a faulty design would show it:
- Key order. A design that starts from the cipher key, or walks the schedule forward, gives garbage for every block. The bench builds its own forward cipher and checks that the published answer and two more key/plaintext pairs come back intact.
- Row rotation and the last round. Rotating rows left, or mixing in the tenth stage, also breaks every block.
- Latency. The bench samples the cycle just before the expected output and then the expected cycle itself, so an extra or a missing register shows up.
- Streaming and idle. Three back-to-back blocks, followed by an idle gap, catch stages that drop or reorder blocks. They also catch an output that changes when nothing new arrives.

// File: rtl/aes_inv_pkg.sv
// Package of shared field arithmetic for the inverse cipher.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package aes_inv_pkg;

    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int N_ROW  = 4;
    localparam int N_COL  = BLK_W / (BYTE_W * N_ROW);

    // Multiply by x in GF(2^8)
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    // General product by repeated xtime
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = xtime(p);
        end
        return acc;
    endfunction

    // Field inverse as a^254 (maps 0 to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] r;
        logic [7:0] p;
        logic [7:0] e;
        r = 8'h01;
        p = a;
        e = 8'hfe;
        for (int i = 0; i < 8; i++) begin
            if (e[i]) r = gmul(r, p);
            p = gmul(p, p);
        end
        return r;
    endfunction

    // Inverse substitution: undo the affine map, then invert in the field
    function automatic logic [7:0] inv_sbox(input logic [7:0] s);
        logic [7:0] t;
        t = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
        return gf_inv(t);
    endfunction

endpackage

// File: rtl/aes_inv_shift_sub.sv
// Combinational inverse row rotation followed by inverse byte substitution.
// Assumes column-major byte order, byte 0 in the top bits of the block.
module aes_inv_shift_sub
    import aes_inv_pkg::*;
(
    input  logic [BLK_W-1:0] state_i,
    output logic [BLK_W-1:0] state_o
);

    // Each output byte takes the byte from column c-r of the same row
    for (genvar c = 0; c < N_COL; c++) begin : g_col
        for (genvar r = 0; r < N_ROW; r++) begin : g_row
            localparam int DST = N_ROW * c + r;
            localparam int SRC = N_ROW * ((c - r + N_COL) % N_COL) + r;
            assign state_o[BLK_W-1-BYTE_W*DST -: BYTE_W] =
                inv_sbox(state_i[BLK_W-1-BYTE_W*SRC -: BYTE_W]);
        end
    end

endmodule

// File: rtl/aes_inv_mix_col.sv
// Combinational inverse column mix of one 4-byte column.
// Assumes row 0 in the top byte; matrix rows are {0e,0b,0d,09} rotated.
module aes_inv_mix_col
    import aes_inv_pkg::*;
(
    input  logic [31:0] col_i,
    output logic [31:0] col_o
);

    logic [7:0] a0, a1, a2, a3;

    // Split the column into its row bytes
    assign {a0, a1, a2, a3} = col_i;

    // One matrix row per output byte
    assign col_o[31:24] = gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09);
    assign col_o[23:16] = gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d);
    assign col_o[15:8]  = gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b);
    assign col_o[7:0]   = gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e);

endmodule

// File: rtl/aes_inv_round.sv
// One registered inverse round: inverse rotate, inverse substitute,
// key XOR, then inverse mix unless round_i equals LAST_ROUND.
// Assumes valid_i is the previous stage's done pulse and the key is steady.
module aes_inv_round
    import aes_inv_pkg::*;
#(
    parameter int LAST_ROUND = 10,
    parameter int ROUND_W    = $clog2(LAST_ROUND + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [ROUND_W-1:0] round_i,
    input  logic [BLK_W-1:0]   state_i,
    input  logic [BLK_W-1:0]   rkey_i,
    output logic [BLK_W-1:0]   state_o,
    output logic               done_o
);

    logic [BLK_W-1:0] shifted;
    logic [BLK_W-1:0] keyed;
    logic [BLK_W-1:0] mixed;
    logic [BLK_W-1:0] nxt;
    logic             is_last;

    aes_inv_shift_sub u_ss (.state_i(state_i), .state_o(shifted));

    // Add the round key after substitution
    assign keyed = shifted ^ rkey_i;

    for (genvar c = 0; c < N_COL; c++) begin : g_mix
        aes_inv_mix_col u_mc (
            .col_i(keyed[BLK_W-1-32*c -: 32]),
            .col_o(mixed[BLK_W-1-32*c -: 32])
        );
    end

    // Final round bypasses the column mix
    assign is_last = (round_i == ROUND_W'(LAST_ROUND));
    assign nxt     = is_last ? keyed : mixed;

    // Load state and raise done one cycle after an enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= valid_i;
            if (valid_i) state_o <= nxt;
        end
    end

    // R4: an enabled stage finishes exactly one cycle later
    a_r4_stage_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    // R6: with no enable there is no done pulse
    a_r6_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);

    // R6: with no enable the stage keeps its state
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(state_o));

    // R1: reset clears the done flag
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!done_o && state_o == '0));

endmodule

// File: rtl/aes_inv_pipe.sv
// Ten-deep inverse cipher pipeline with the initial key XOR in front.
// Assumes rkeys_i holds key k at slice k and stays steady while blocks move.
module aes_inv_pipe
    import aes_inv_pkg::*;
#(
    parameter int NR      = 10,
    parameter int ROUND_W = $clog2(NR + 1),
    parameter int KEYS_W  = (NR + 1) * BLK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BLK_W-1:0]   cipher_i,
    input  logic [KEYS_W-1:0]  rkeys_i,
    output logic               out_valid,
    output logic [BLK_W-1:0]   plain_o
);

    logic [BLK_W-1:0] st  [0:NR];
    logic             vld [0:NR];

    // First whitening with the last key of the schedule
    assign st[0]  = cipher_i ^ rkeys_i[NR*BLK_W +: BLK_W];
    assign vld[0] = in_valid;

    for (genvar r = 1; r <= NR; r++) begin : g_stage
        aes_inv_round #(.LAST_ROUND(NR), .ROUND_W(ROUND_W)) u_round (
            .clk    (clk),
            .rst_n  (rst_n),
            .valid_i(vld[r-1]),
            .round_i(ROUND_W'(r)),
            .state_i(st[r-1]),
            .rkey_i (rkeys_i[(NR-r)*BLK_W +: BLK_W]),
            .state_o(st[r]),
            .done_o (vld[r])
        );
    end

    assign out_valid = vld[NR];
    assign plain_o   = st[NR];

endmodule

// File: tb/aes_inv_pipe_test.sv
// Directed bench: builds its own forward cipher, decrypts with the pipeline.
module aes_inv_pipe_test;

    localparam int NR = 10;
    localparam int KW = (NR + 1) * 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [127:0]  cipher_i = '0;
    logic [KW-1:0] rkeys_i = '0;
    logic          out_valid;
    logic [127:0]  plain_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    aes_inv_pipe uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cipher_i(cipher_i),
        .rkeys_i(rkeys_i), .out_valid(out_valid), .plain_o(plain_o)
    );

    // ---------- bench reference: forward cipher ----------
    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] x = a, y = b, acc = 0;
        while (y != 0) begin
            if (y[0]) acc ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
            y = y >> 1;
        end
        return acc;
    endfunction

    function automatic logic [7:0] fsbox(input logic [7:0] a);
        logic [7:0] inv = 0, b;
        if (a != 0)
            for (int k = 1; k < 256; k++)
                if (bmul(a, 8'(k)) == 8'h01) inv = 8'(k);
        b = inv;
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [7:0] gb(input logic [127:0] s, input int n);
        return s[127-8*n -: 8];
    endfunction

    function automatic logic [KW-1:0] expand(input logic [127:0] key);
        logic [31:0] w [0:4*(NR+1)-1];
        logic [31:0] t;
        logic [7:0]  rc = 8'h01;
        logic [KW-1:0] out;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 4*(NR+1); i++) begin
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {fsbox(t[31:24]), fsbox(t[23:16]), fsbox(t[15:8]), fsbox(t[7:0])};
                t = t ^ {rc, 24'h0};
                rc = bmul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ t;
        end
        for (int k = 0; k <= NR; k++)
            out[k*128 +: 128] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
        return out;
    endfunction

    function automatic logic [127:0] encrypt(input logic [127:0] pt, input logic [KW-1:0] rk);
        logic [127:0] s, t;
        s = pt ^ rk[127:0];
        for (int r = 1; r <= NR; r++) begin
            for (int n = 0; n < 16; n++) t[127-8*n -: 8] = fsbox(gb(s, n));
            s = t;
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++)
                    t[127-8*(4*c+w) -: 8] = gb(s, 4*((c+w)%4)+w);
            s = t;
            if (r < NR)
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = gb(s, 4*c); a1 = gb(s, 4*c+1); a2 = gb(s, 4*c+2); a3 = gb(s, 4*c+3);
                    t[127-32*c -: 32] = {
                        bmul(a0,2) ^ bmul(a1,3) ^ a2 ^ a3,
                        a0 ^ bmul(a1,2) ^ bmul(a2,3) ^ a3,
                        a0 ^ a1 ^ bmul(a2,2) ^ bmul(a3,3),
                        bmul(a0,3) ^ a1 ^ a2 ^ bmul(a3,2)};
                end
            s = t ^ rk[r*128 +: 128];
        end
        return s;
    endfunction

    // ---------- checking ----------
    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'h0);
        check(plain_o == '0, "R1 plain_o", plain_o, 128'h0);
    endtask

    // R2/R3/R4: one block, exact latency and value
    task automatic t_single(input logic [127:0] key, input logic [127:0] pt, input string req);
        logic [127:0] ct;
        rkeys_i = expand(key);
        ct = encrypt(pt, rkeys_i);
        @(negedge clk);
        in_valid = 1'b1; cipher_i = ct;
        @(negedge clk);
        in_valid = 1'b0; cipher_i = '0;
        repeat (8) @(negedge clk);
        check(out_valid == 1'b0, "R4 early out_valid", 128'(out_valid), 128'h0);
        @(negedge clk);
        check(out_valid == 1'b1, "R4 out_valid at tenth edge", 128'(out_valid), 128'h1);
        check(plain_o == pt, req, plain_o, pt);
    endtask

    // R2: bench model agrees with the published answer
    task automatic t_model();
        logic [127:0] ct;
        ct = encrypt(128'h00112233445566778899aabbccddeeff, expand(128'h000102030405060708090a0b0c0d0e0f));
        check(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R2 reference ciphertext", ct,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    endtask

    // R5/R6: three blocks back to back, then idle
    task automatic t_stream();
        logic [127:0] pt [0:2];
        pt[0] = 128'h0123456789abcdeffedcba9876543210;
        pt[1] = 128'hffffffffffffffffffffffffffffffff;
        pt[2] = 128'h00000000000000000000000000000001;
        rkeys_i = expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; cipher_i = encrypt(pt[i], rkeys_i);
        end
        @(negedge clk);
        in_valid = 1'b0; cipher_i = '0;
        repeat (7) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check(out_valid == 1'b1, "R5 streamed out_valid", 128'(out_valid), 128'h1);
            check(plain_o == pt[i], "R5 streamed order/value", plain_o, pt[i]);
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R6 out_valid drops when idle", 128'(out_valid), 128'h0);
        repeat (3) @(negedge clk);
        check(plain_o == pt[2], "R6 plain_o holds when idle", plain_o, pt[2]);
    endtask

    initial begin
        t_reset();
        t_model();
        t_single(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
                 "R2 known-answer plaintext");
        t_single(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
                 "R3 key order, second pair");
        t_single(128'hffffffffffffffffffffffffffffffff, 128'h5a5aa5a5c3c33c3c0f0ff0f012345678,
                 "R3 key order, third pair");
        t_stream();
        summary();
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 128'h0, 128'h1);
        summary();
    end

endmodule